// File: doc/BRIEF.md
# Multi-channel compare system timer

This peripheral keeps one shared up-counter. The module clock reaches the counter through a programmable prescaler. Several compare channels watch the counter. Each channel holds its own compare value, its own enable and a sticky match flag, and it drives a separate interrupt line while the flag and the enable are both set. Software reaches the control, counter and channel registers through a simple word-wide register bus: a select, a write strobe, a byte address and write data. Reads are combinational.

A match leaves the counter running. The counter keeps advancing and wraps, so a one-shot event is made by software turning the channel off in its interrupt handler. Software may load the counter at any time. A debug-halt input stops counting, but only when the control register allows it.

Top module: `sys_cmp_timer`

## Requirements
- R1: After reset the control register, the counter, every channel enable, compare value and flag read as zero, and all interrupt outputs are low.
- R2: While the run bit (control bit 0) is set, the counter advances by one every P+1 clock cycles, where P is control bits 15:8. Clearing the run bit restarts the prescale divider from zero, so the first increment after the run bit is set again comes P+1 cycles later.
- R3: The counter wraps from all-ones to zero.
- R4: When control bit 1 is set and the debug-halt input is high, the counter holds. If either of the two is low, counting continues.
- R5: A write to offset 0x04 loads the counter. The written value wins over an increment in the same cycle.
- R6: Register map with readback. Offset 0x00 is control: bit 0 run, bit 1 debug freeze, bits 15:8 prescale, other bits read zero. Offset 0x04 is the counter. Channel n has its enable in bit 0 at 0x10+0x10·n, its flag in bit 0 at 0x14+0x10·n, and its compare value at 0x18+0x10·n.
- R7: A channel flag sets only on a prescale tick where the channel is enabled and the counter steps onto the compare value. A software load of the counter never sets it, and a disabled channel never sets it.
- R8: A flag stays set until software writes 1 to its bit 0. Writing 0 has no effect. If a match and a clear fall in the same cycle, the flag stays set.
- R9: Each interrupt output is high exactly when that channel's flag and enable are both set. Clearing the enable hides a set flag without clearing it.
- R10: A match neither stops nor reloads the counter.
- R11: Reads of unmapped offsets (0x08, 0x0C, unused channel words, offsets past the last channel) return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_halt | input | 1 | Debug-halt request |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (read when low) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq | output | NCH | One interrupt per compare channel |

## Verification
The bench builds the block with its default configuration: a 32-bit counter, an 8-bit prescale field and four channels. With four channels, every channel can be given its own prescale and compare pair, so each interrupt line is checked alone against the product compare·(P+1). The prescale field is swept over 0 to 7 against every elapsed-cycle count from 0 to 20, and each result is checked against floor(cycles/(P+1)). Divide-by-256 is then checked at its edges. A preload near all-ones brings the wrap within two cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [31:0] OFS_CTRL  = 32'h00;
    localparam logic [31:0] OFS_COUNT = 32'h04;
    localparam logic [31:0] CH_BASE   = 32'h10;
    localparam logic [31:0] CH_STRIDE = 32'h10;
    localparam logic [3:0]  CH_CTL    = 4'h0;
    localparam logic [3:0]  CH_FLAG   = 4'h4;
    localparam logic [3:0]  CH_CMP    = 4'h8;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_COUNT,
        RK_CH_CTL,
        RK_CH_FLAG,
        RK_CH_CMP
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] ch;
    } reg_sel_t;

    // Map a byte offset to a register kind and channel index
    function automatic reg_sel_t decode(input logic [31:0] a, input int unsigned nch);
        reg_sel_t    s;
        logic [31:0] rel;
        s.kind = RK_NONE;
        s.ch   = '0;
        rel    = a - CH_BASE;
        if (a == OFS_CTRL) begin
            s.kind = RK_CTRL;
        end else if (a == OFS_COUNT) begin
            s.kind = RK_COUNT;
        end else if (a >= CH_BASE && a < CH_BASE + CH_STRIDE * nch) begin
            s.ch = rel[11:4];
            case (rel[3:0])
                CH_CTL:  s.kind = RK_CH_CTL;
                CH_FLAG: s.kind = RK_CH_FLAG;
                CH_CMP:  s.kind = RK_CH_CMP;
                default: s.kind = RK_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [31:0] ch_addr(input int unsigned n, input logic [3:0] ofs);
        return CH_BASE + CH_STRIDE * n + {28'd0, ofs};
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             frz_en,
    input  logic             dbg_halt,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;
    logic             active;

    always_comb begin
        active = run_en && !(frz_en && dbg_halt);
        tick   = active && (div_q == pre);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            div_q <= '0;
        end else if (active) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] cnt_nxt
);
    assign cnt_nxt = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cnt_ld,
    input  logic [DATA_W-1:0] cnt_nxt,
    input  logic              ctl_wr,
    input  logic              flag_wr,
    input  logic              cmp_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              en_q,
    output logic              flag_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic              irq
);
    logic hit;

    always_comb begin
        hit = tick && !cnt_ld && en_q && (cnt_nxt == cmp_q);
        irq = flag_q && en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            flag_q <= 1'b0;
            cmp_q  <= '0;
        end else begin
            if (ctl_wr) en_q <= wdata[0];
            if (cmp_wr) cmp_q <= wdata;
            if (hit) begin
                flag_q <= 1'b1;
            end else if (flag_wr && wdata[0]) begin
                flag_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NCH    = 4,
    parameter int unsigned PRE_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       wd_run,
    input  logic                       wd_frz,
    input  logic [PRE_W-1:0]           wd_pre,
    input  logic [DATA_W-1:0]          cnt_q,
    input  logic [NCH-1:0]             ch_en,
    input  logic [NCH-1:0]             ch_flag,
    input  logic [NCH-1:0][DATA_W-1:0] ch_cmp,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       ctrl_en,
    output logic                       ctrl_frz,
    output logic [PRE_W-1:0]           ctrl_pre,
    output logic                       cnt_wr,
    output logic [NCH-1:0]             ch_ctl_wr,
    output logic [NCH-1:0]             ch_flag_wr,
    output logic [NCH-1:0]             ch_cmp_wr
);
    localparam int unsigned PRE_LSB = 8;

    reg_sel_t sel;
    logic     wr_go;

    always_comb begin
        sel    = decode(32'(bus_addr), NCH);
        wr_go  = bus_sel && bus_wr;
        cnt_wr = wr_go && (sel.kind == RK_COUNT);
        for (int i = 0; i < NCH; i++) begin
            ch_ctl_wr[i]  = wr_go && (sel.kind == RK_CH_CTL)  && (sel.ch == 8'(i));
            ch_flag_wr[i] = wr_go && (sel.kind == RK_CH_FLAG) && (sel.ch == 8'(i));
            ch_cmp_wr[i]  = wr_go && (sel.kind == RK_CH_CMP)  && (sel.ch == 8'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en  <= 1'b0;
            ctrl_frz <= 1'b0;
            ctrl_pre <= '0;
        end else if (wr_go && sel.kind == RK_CTRL) begin
            ctrl_en  <= wd_run;
            ctrl_frz <= wd_frz;
            ctrl_pre <= wd_pre;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (sel.kind)
                RK_CTRL: begin
                    bus_rdata[0]                = ctrl_en;
                    bus_rdata[1]                = ctrl_frz;
                    bus_rdata[PRE_LSB +: PRE_W] = ctrl_pre;
                end
                RK_COUNT: bus_rdata = cnt_q;
                RK_CH_CTL: begin
                    for (int i = 0; i < NCH; i++)
                        if (sel.ch == 8'(i)) bus_rdata[0] = ch_en[i];
                end
                RK_CH_FLAG: begin
                    for (int i = 0; i < NCH; i++)
                        if (sel.ch == 8'(i)) bus_rdata[0] = ch_flag[i];
                end
                RK_CH_CMP: begin
                    for (int i = 0; i < NCH; i++)
                        if (sel.ch == 8'(i)) bus_rdata = ch_cmp[i];
                end
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sys_cmp_timer.sv
module sys_cmp_timer #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NCH    = 4,
    parameter int unsigned PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_halt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);
    localparam int unsigned PRE_LSB = 8;

    logic                       ctrl_en;
    logic                       ctrl_frz;
    logic [PRE_W-1:0]           ctrl_pre;
    logic                       cnt_wr;
    logic                       tick;
    logic [DATA_W-1:0]          cnt_q;
    logic [DATA_W-1:0]          cnt_nxt;
    logic [NCH-1:0]             ch_ctl_wr;
    logic [NCH-1:0]             ch_flag_wr;
    logic [NCH-1:0]             ch_cmp_wr;
    logic [NCH-1:0]             ch_en;
    logic [NCH-1:0]             ch_flag;
    logic [NCH-1:0][DATA_W-1:0] ch_cmp;

    tmr_regbank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NCH(NCH), .PRE_W(PRE_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .wd_run     (bus_wdata[0]),
        .wd_frz     (bus_wdata[1]),
        .wd_pre     (bus_wdata[PRE_LSB +: PRE_W]),
        .cnt_q      (cnt_q),
        .ch_en      (ch_en),
        .ch_flag    (ch_flag),
        .ch_cmp     (ch_cmp),
        .bus_rdata  (bus_rdata),
        .ctrl_en    (ctrl_en),
        .ctrl_frz   (ctrl_frz),
        .ctrl_pre   (ctrl_pre),
        .cnt_wr     (cnt_wr),
        .ch_ctl_wr  (ch_ctl_wr),
        .ch_flag_wr (ch_flag_wr),
        .ch_cmp_wr  (ch_cmp_wr)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run_en   (ctrl_en),
        .frz_en   (ctrl_frz),
        .dbg_halt (dbg_halt),
        .pre      (ctrl_pre),
        .tick     (tick)
    );

    tmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ld      (cnt_wr),
        .ld_val  (bus_wdata),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel #(.DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .cnt_ld  (cnt_wr),
            .cnt_nxt (cnt_nxt),
            .ctl_wr  (ch_ctl_wr[g]),
            .flag_wr (ch_flag_wr[g]),
            .cmp_wr  (ch_cmp_wr[g]),
            .wdata   (bus_wdata),
            .en_q    (ch_en[g]),
            .flag_q  (ch_flag[g]),
            .cmp_q   (ch_cmp[g]),
            .irq     (irq[g])
        );
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NCH    = 4,
    parameter int unsigned PRE_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              dbg_halt,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NCH-1:0]    irq,
    input logic [DATA_W-1:0] cnt_q,
    input logic              tick,
    input logic              ctrl_en,
    input logic              ctrl_frz,
    input logic [PRE_W-1:0]  ctrl_pre,
    input logic [NCH-1:0]    ch_en,
    input logic [NCH-1:0]    ch_flag
);
    logic cnt_load, ctrl_load;
    assign cnt_load  = bus_sel && bus_wr && (32'(bus_addr) == OFS_COUNT);
    assign ctrl_load = bus_sel && bus_wr && (32'(bus_addr) == OFS_CTRL);

    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (cnt_q == '0 && irq == '0)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_load) |=> $stable(cnt_q)); // R2
    AST_PRE_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl_pre != '0 && !ctrl_load) |=> !tick); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load && cnt_q == '1) |=> (cnt_q == '0)); // R3
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && ctrl_frz && dbg_halt) |-> !tick); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> (cnt_q == $past(bus_wdata))); // R5

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_flag[g]) |-> ($past(tick) && $past(ch_en[g]) && !$past(cnt_load))); // R7
        AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
            $fell(ch_flag[g]) |-> $past(bus_sel && bus_wr && bus_wdata[0] &&
                (32'(bus_addr) == ch_addr(g, CH_FLAG)))); // R8
    end
endmodule

bind sys_cmp_timer tmr_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NCH(NCH), .PRE_W(PRE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dbg_halt  (dbg_halt),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cnt_q     (cnt_q),
    .tick      (tick),
    .ctrl_en   (ctrl_en),
    .ctrl_frz  (ctrl_frz),
    .ctrl_pre  (ctrl_pre),
    .ch_en     (ch_en),
    .ch_flag   (ch_flag)
);

// File: tb/sys_cmp_timer_tb.sv
module sys_cmp_timer_tb;
    localparam int CLK_P  = 10;
    localparam int NCH    = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dbg = 1'b0;
    logic              sel = 1'b0;
    logic              wr  = 1'b0;
    logic [7:0]        addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [NCH-1:0]    irq;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #(CLK_P/2) clk = ~clk;

    sys_cmp_timer #(.DATA_W(DATA_W), .ADDR_W(8), .NCH(NCH), .PRE_W(8)) u_dut (
        .clk(clk), .rst(rst), .dbg_halt(dbg), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    function automatic logic [7:0] cha(input int n, input int ofs);
        return 8'(16 + 16 * n + ofs);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one write, consumes exactly one rising edge, returns 1 time unit after it
    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1; d = rdata;
        sel = 1'b0;
    endtask

    task automatic tk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic quiesce();
        bw(8'h00, 32'h0);
        for (int j = 0; j < NCH; j++) begin
            bw(cha(j, 0), 32'h0);
            bw(cha(j, 4), 32'h1);
        end
        bw(8'h04, 32'h0);
    endtask

    logic [31:0] v;

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tk(3);
        @(negedge clk); rst = 1'b0;
        tk(1);
        // R1 reset values
        br(8'h00, v); chk("R1 ctrl", v, 0);
        br(8'h04, v); chk("R1 counter", v, 0);
        for (int j = 0; j < NCH; j++) begin
            br(cha(j, 0), v); chk("R1 ch enable", v, 0);
            br(cha(j, 4), v); chk("R1 ch flag", v, 0);
            br(cha(j, 8), v); chk("R1 ch compare", v, 0);
        end
        chk("R1 irq", 32'(irq), 0);

        // R6 readback
        bw(8'h00, 32'h0000_AB02); br(8'h00, v); chk("R6 ctrl readback", v, 32'h0000_AB02);
        bw(8'h00, 32'hFFFF_FFFF); br(8'h00, v); chk("R6 ctrl masked", v, 32'h0000_FF03);
        bw(8'h00, 32'h0);
        for (int j = 0; j < NCH; j++) begin
            bw(cha(j, 8), 32'hC0DE_0000 + 32'(j)); br(cha(j, 8), v);
            chk("R6 compare readback", v, 32'hC0DE_0000 + 32'(j));
            bw(cha(j, 0), 32'hFFFF_FFFF); br(cha(j, 0), v); chk("R6 enable bit only", v, 1);
            bw(cha(j, 0), 32'h0);
        end

        // R11 unmapped offsets
        bw(8'h04, 32'h1234_5678);
        bw(8'h00, 32'h0000_0500);
        foreach (v[i]) ;
        begin
            logic [7:0] holes [6] = '{8'h08, 8'h0C, 8'h1C, 8'h3C, 8'h50, 8'h80};
            for (int k = 0; k < 6; k++) begin
                bw(holes[k], 32'hFFFF_FFFF);
                br(holes[k], v); chk("R11 unmapped read", v, 0);
            end
        end
        br(8'h00, v); chk("R11 ctrl untouched", v, 32'h0000_0500);
        br(8'h04, v); chk("R11 counter untouched", v, 32'h1234_5678);
        for (int j = 0; j < NCH; j++) begin
            br(cha(j, 0), v); chk("R11 ch enable untouched", v, 0);
        end

        // R2 prescale sweep
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m <= 20; m++) begin
                bw(8'h00, 32'h0);
                bw(8'h04, 32'h0);
                bw(8'h00, (32'(p) << 8) | 32'h1);
                tk(m);
                br(8'h04, v);
                chk("R2 prescale count", v, 32'(m / (p + 1)));
            end
        end
        for (int k = 0; k < 3; k++) begin
            int m;
            m = (k == 0) ? 255 : (k == 1) ? 256 : 512;
            bw(8'h00, 32'h0); bw(8'h04, 32'h0);
            bw(8'h00, 32'h0000_FF01);
            tk(m);
            br(8'h04, v); chk("R2 divide by 256", v, 32'(m / 256));
        end
        // R2 divider restarts after disable
        bw(8'h00, 32'h0); bw(8'h04, 32'h0);
        bw(8'h00, 32'h0000_0301);
        tk(2);
        bw(8'h00, 32'h0);
        bw(8'h00, 32'h0000_0301);
        tk(3); br(8'h04, v); chk("R2 divider restart, none yet", v, 0);
        tk(1); br(8'h04, v); chk("R2 divider restart, first step", v, 1);

        // R3 wrap
        bw(8'h00, 32'h0); bw(8'h04, 32'hFFFF_FFFE);
        bw(8'h00, 32'h1);
        tk(1); br(8'h04, v); chk("R3 all ones", v, 32'hFFFF_FFFF);
        tk(1); br(8'h04, v); chk("R3 wrap to zero", v, 0);

        // R4 freeze
        bw(8'h00, 32'h0); bw(8'h04, 32'h0);
        bw(8'h00, 32'h3);
        tk(4); br(8'h04, v); chk("R4 freeze bit, no halt", v, 4);
        dbg = 1'b1;
        tk(5); br(8'h04, v); chk("R4 frozen", v, 4);
        dbg = 1'b0;
        tk(2); br(8'h04, v); chk("R4 resumed", v, 6);
        dbg = 1'b1;
        bw(8'h00, 32'h1);
        tk(3); br(8'h04, v); chk("R4 halt ignored without freeze bit", v, 9);
        dbg = 1'b0;

        // R5 load beats increment
        bw(8'h04, 32'd100);
        br(8'h04, v); chk("R5 load wins", v, 100);
        tk(1); br(8'h04, v); chk("R5 counts from loaded", v, 101);

        // R7 / R10 / R8 channel 0 basic match
        quiesce();
        bw(cha(0, 8), 32'd5); bw(cha(0, 0), 32'h1);
        bw(8'h00, 32'h1);
        tk(4); chk("R7 no early match", 32'(irq), 0);
        br(cha(0, 4), v); chk("R7 flag still clear", v, 0);
        tk(1); chk("R7 match irq", 32'(irq), 1);
        br(cha(0, 4), v); chk("R7 flag set", v, 1);
        br(8'h04, v); chk("R10 counter at compare", v, 5);
        tk(3); br(8'h04, v); chk("R10 keeps counting", v, 8);
        chk("R8 flag sticky", 32'(irq), 1);
        bw(cha(0, 4), 32'h0); br(cha(0, 4), v); chk("R8 write zero no effect", v, 1);
        bw(cha(0, 4), 32'h1); br(cha(0, 4), v); chk("R8 write one clears", v, 0);
        chk("R8 irq drops", 32'(irq), 0);
        tk(1); br(cha(0, 4), v); chk("R8 stays clear", v, 0);

        // R7 per channel sweep with own prescale
        for (int c = 0; c < NCH; c++) begin
            int cmpv;
            cmpv = 3 + 2 * c;
            quiesce();
            bw(cha(c, 8), 32'(cmpv)); bw(cha(c, 0), 32'h1);
            bw(8'h00, (32'(c) << 8) | 32'h1);
            tk(cmpv * (c + 1) - 1); chk("R7 channel before match", 32'(irq), 0);
            tk(1); chk("R7 channel own irq", 32'(irq), 32'(1 << c));
        end

        // R7 disabled channel, software load
        quiesce();
        bw(cha(1, 8), 32'd2);
        bw(8'h00, 32'h1);
        tk(4); br(cha(1, 4), v); chk("R7 disabled channel no flag", v, 0);
        chk("R7 disabled channel no irq", 32'(irq), 0);
        bw(8'h00, 32'h0);
        bw(cha(0, 8), 32'd7); bw(cha(0, 0), 32'h1);
        bw(8'h04, 32'd7);
        br(cha(0, 4), v); chk("R7 load does not set flag", v, 0);

        // R9 masking
        quiesce();
        bw(cha(2, 8), 32'd2); bw(cha(2, 0), 32'h1);
        bw(8'h00, 32'h1);
        tk(2); chk("R9 irq on", 32'(irq), 32'h4);
        bw(cha(2, 0), 32'h0);
        chk("R9 irq masked", 32'(irq), 0);
        br(cha(2, 4), v); chk("R9 flag kept", v, 1);
        bw(cha(2, 0), 32'h1);
        chk("R9 irq back", 32'(irq), 32'h4);

        // R8 set wins over clear in same cycle
        quiesce();
        bw(cha(3, 8), 32'd4); bw(cha(3, 0), 32'h1);
        bw(8'h00, 32'h1);
        tk(3);
        bw(cha(3, 4), 32'h1);
        br(cha(3, 4), v); chk("R8 match beats clear", v, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule